// File: doc/BRIEF.md
# Sum-of-Products Logic Cell

This block is one logic cell of a programmable-logic fabric. It takes a vector of signals gathered from the shared global bus and its logic block's regional bus. From them it forms five product terms, and each term is an AND over any chosen set of those signals, each taken in true or complemented form. A steering stage decides, term by term, whether the term joins the cell's OR sum or is handed out on a side port for control use. The OR sum can take in a cascade signal from the neighbouring cell and passes the widened sum on through a cascade output, so that adjacent cells can build wide sums. An XOR stage then sets the polarity of the cell output, or merges in one product term.

The cell also drives a foldback signal for the regional bus: the complement of one chosen product term. All behaviour is set by one static configuration vector. The cell is purely combinational, and every output follows its inputs within the same cycle.

Top module: `sop_macrocell`

## Requirements
- R1: The cell forms exactly five product terms. Term i is configured by the field `cfg[i*2*NUM_IN +: 2*NUM_IN]`, which holds two bits for each bus input j. Bit 2j set requires `bus_in[j]` to be 1, and bit 2j+1 set requires `bus_in[j]` to be 0. The term is the AND of all such conditions.
- R2: A term whose field is all zero, so that every input is ignored, evaluates to 0.
- R3: If both bits of any input of a term are set, that term is 0 for every bus value.
- R4: Steering bit i, at `cfg[AW+i]` with AW = 10*NUM_IN, set to 1 sends term i into the OR sum and holds `pt_ctrl[i]` at 0. Set to 0, it leaves term i out of the sum and drives the term on `pt_ctrl[i]`.
- R5: The cascade-enable bit `cfg[AW+5]` ORs `cas_in` into the sum. When that bit is 0, `cas_in` has no effect. `cas_out` always carries the full sum.
- R6: The two-bit XOR mode at `cfg[AW+7:AW+6]` selects the second XOR input. The codes are 0 for a constant 0, 1 for a constant 1, 2 for the product term indexed by `cfg[AW+10:AW+8]` (taken as 0 when that index is 5 or more), and 3 for a constant 0. `cell_out` is the sum XOR that input.
- R7: `fold_out` is the complement of the product term indexed by `cfg[AW+13:AW+11]`. It is 1 when that index is 5 or more.
- R8: Eight cells chained from `cas_out` to `cas_in`, with the first cell's cascade disabled, produce a single 40-term sum at the last cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_in | input | NUM_IN | Selected global and regional bus signals |
| cfg | input | 10*NUM_IN+14 | Static configuration vector |
| cas_in | input | 1 | Sum from the neighbouring cell |
| cas_out | output | 1 | Local sum including the accepted cascade |
| cell_out | output | 1 | Sum after the XOR polarity stage |
| pt_ctrl | output | 5 | Terms steered away from the sum |
| fold_out | output | 1 | Complemented term for the regional bus |

## Verification
The bench builds the cell with NUM_IN = 8. At that width an 8-bit bus sweep can visit every bus value, so a chain of eight cells, each holding five terms that decode one distinct bus value, shows the 40-term sum rising on exactly 40 of the 64 swept values. A narrow bus also means that random configurations often leave some terms true, so the comparison against the behavioural model exercises the steering and the XOR term selection with live terms instead of terms stuck at zero.

// File: rtl/sop_macrocell.sv
module sop_macrocell #(
  parameter int NUM_IN = 40
) (
  input  logic [NUM_IN-1:0]        bus_in,
  input  logic [10*NUM_IN+13:0]    cfg,
  input  logic                     cas_in,
  output logic                     cas_out,
  output logic                     cell_out,
  output logic [4:0]               pt_ctrl,
  output logic                     fold_out
);
  localparam int NPT   = 5;
  localparam int PW    = 2 * NUM_IN;
  localparam int AW    = NPT * PW;
  localparam int ST_LO = AW;
  localparam int CE_B  = AW + NPT;
  localparam int XM_LO = AW + NPT + 1;
  localparam int XS_LO = XM_LO + 2;
  localparam int FS_LO = XS_LO + 3;

  logic [NPT-1:0] pt;
  logic [NPT-1:0] steer;
  logic [1:0]     xmode;
  logic [2:0]     xsel, fsel;
  logic           cas_en, local_or, xterm, fterm, xin;

  for (genvar i = 0; i < NPT; i++) begin : g_term
    logic [NUM_IN-1:0] used, hit;
    for (genvar j = 0; j < NUM_IN; j++) begin : g_lit
      assign used[j] = cfg[i*PW + 2*j] | cfg[i*PW + 2*j + 1];
      assign hit[j]  = (~cfg[i*PW + 2*j] | bus_in[j]) & (~cfg[i*PW + 2*j + 1] | ~bus_in[j]);
    end
    assign pt[i] = (|used) & (&hit);
  end

  assign steer    = cfg[ST_LO +: NPT];
  assign cas_en   = cfg[CE_B];
  assign xmode    = cfg[XM_LO +: 2];
  assign xsel     = cfg[XS_LO +: 3];
  assign fsel     = cfg[FS_LO +: 3];

  assign pt_ctrl  = pt & ~steer;
  assign local_or = |(pt & steer);
  assign cas_out  = local_or | (cas_en & cas_in);

  always_comb begin
    xterm = 1'b0;
    fterm = 1'b0;
    if (xsel < 3'(NPT)) xterm = pt[xsel];
    if (fsel < 3'(NPT)) fterm = pt[fsel];
    case (xmode)
      2'd1:    xin = 1'b1;
      2'd2:    xin = xterm;
      default: xin = 1'b0;
    endcase
  end

  assign cell_out = cas_out ^ xin;
  assign fold_out = ~fterm;

  always_comb begin
    AST_CASCADE_PASS: assert (!(cas_en && cas_in) || cas_out) else $error("cascade lost"); // R5
    AST_NO_STEER_SUM: assert ((steer != '0) || cas_en || !cas_out) else $error("sum without source"); // R4
    AST_STEER_SPLIT:  assert ((pt_ctrl & steer) == '0) else $error("term on both paths"); // R4
    AST_XOR_ZERO:     assert ((xmode != 2'd0) || (cell_out == cas_out)) else $error("xor zero"); // R6
    AST_XOR_ONE:      assert ((xmode != 2'd1) || (cell_out != cas_out)) else $error("xor one"); // R6
  end
endmodule

// File: tb/sop_macrocell_bench.sv
module sop_macrocell_bench;
  localparam int N   = 8;
  localparam int PW  = 2 * N;
  localparam int AW  = 5 * PW;
  localparam int CW  = AW + 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]  bus;
  logic [CW-1:0] cfg;
  logic          cin;
  logic          cout, fout, fold;
  logic [4:0]    ctrl;

  int checks = 0;
  int errors = 0;

  sop_macrocell #(.NUM_IN(N)) u_sop_macrocell (
    .bus_in(bus), .cfg(cfg), .cas_in(cin),
    .cas_out(cout), .cell_out(fout), .pt_ctrl(ctrl), .fold_out(fold)
  );

  logic [CW-1:0] ccfg [8];
  logic [8:0]    chn;
  logic [7:0]    cfo;
  assign chn[0] = 1'b0;
  for (genvar k = 0; k < 8; k++) begin : g_chain
    logic [4:0] cc;
    logic       cf;
    sop_macrocell #(.NUM_IN(N)) u_cell (
      .bus_in(bus), .cfg(ccfg[k]), .cas_in(chn[k]),
      .cas_out(chn[k+1]), .cell_out(cfo[k]), .pt_ctrl(cc), .fold_out(cf)
    );
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic mterm(input logic [CW-1:0] c, input int i, input logic [N-1:0] b);
    logic any = 1'b0;
    logic r = 1'b1;
    for (int j = 0; j < N; j++) begin
      logic [1:0] code = c[i*PW + 2*j +: 2];
      if (code != 2'b00) any = 1'b1;
      if (code[0] && !b[j]) r = 1'b0;
      if (code[1] && b[j]) r = 1'b0;
    end
    return any & r;
  endfunction

  task automatic apply(input logic [CW-1:0] c, input logic [N-1:0] b, input logic ci);
    @(posedge clk);
    cfg = c; bus = b; cin = ci;
    @(negedge clk);
  endtask

  function automatic logic [CW-1:0] set_field(input logic [CW-1:0] c, input int lo, input int w, input int v);
    logic [CW-1:0] r = c;
    for (int k = 0; k < w; k++) r[lo+k] = 1'(v >> k);
    return r;
  endfunction

  task automatic t_reset;
    apply('0, 8'hA5, 1'b0);
    chk("R2 idle ctrl", {3'b0, ctrl}, 8'h0);
    chk("R2 idle sum", {7'b0, cout}, 8'h0);
    chk("R6 idle out", {7'b0, fout}, 8'h0);
    chk("R7 idle fold", {7'b0, fold}, 8'h1);
  endtask

  task automatic t_literals;
    logic [CW-1:0] c = '0;
    c[0*PW + 0] = 1'b1;
    c[0*PW + 2*3 + 1] = 1'b1;
    apply(c, 8'b0000_0001, 1'b0);
    chk("R1 true/compl match", {3'b0, ctrl}, 8'h01);
    apply(c, 8'b0000_1001, 1'b0);
    chk("R1 complement blocks", {3'b0, ctrl}, 8'h00);
    apply(c, 8'b0000_0000, 1'b0);
    chk("R1 true blocks", {3'b0, ctrl}, 8'h00);
  endtask

  task automatic t_empty;
    logic [CW-1:0] c = '0;
    c[2*PW + 4] = 1'b1;
    apply(c, 8'hFF, 1'b0);
    chk("R2 empty terms zero", {3'b0, ctrl}, 8'h04);
  endtask

  task automatic t_conflict;
    logic [CW-1:0] c = '0;
    c[1*PW + 2*5 +: 2] = 2'b11;
    for (int v = 0; v < 4; v++) begin
      apply(c, 8'(v * 37), 1'b0);
      chk("R3 conflicting literal", {7'b0, ctrl[1]}, 8'h0);
    end
  endtask

  task automatic t_steer;
    logic [CW-1:0] c = '0;
    for (int i = 0; i < 5; i++) c[i*PW + 2*i] = 1'b1;
    c = set_field(c, AW, 5, 5'b00101);
    apply(c, 8'b0001_0010, 1'b0);
    chk("R4 side terms", {3'b0, ctrl}, 8'h12);
    chk("R4 sum excludes side", {7'b0, cout}, 8'h0);
    apply(c, 8'b0000_0100, 1'b0);
    chk("R4 steered term in sum", {7'b0, cout}, 8'h1);
    chk("R4 steered term off side", {3'b0, ctrl}, 8'h00);
  endtask

  task automatic t_cascade;
    logic [CW-1:0] c = '0;
    apply(c, 8'h00, 1'b1);
    chk("R5 cascade ignored", {7'b0, cout}, 8'h0);
    c[AW + 5] = 1'b1;
    apply(c, 8'h00, 1'b1);
    chk("R5 cascade accepted", {7'b0, cout}, 8'h1);
    apply(c, 8'h00, 1'b0);
    chk("R5 cascade low", {7'b0, cout}, 8'h0);
  endtask

  task automatic t_xor;
    logic [CW-1:0] c = '0;
    c[3*PW + 0] = 1'b1;
    c[AW + 5] = 1'b1;
    c = set_field(c, AW + 6, 2, 1);
    apply(c, 8'h00, 1'b1);
    chk("R6 const1 inverts", {7'b0, fout}, 8'h0);
    c = set_field(c, AW + 6, 2, 2);
    c = set_field(c, AW + 8, 3, 3);
    apply(c, 8'h01, 1'b1);
    chk("R6 term xor", {7'b0, fout}, 8'h0);
    apply(c, 8'h00, 1'b1);
    chk("R6 term low", {7'b0, fout}, 8'h1);
    c = set_field(c, AW + 8, 3, 6);
    apply(c, 8'h01, 1'b1);
    chk("R6 index out of range", {7'b0, fout}, 8'h1);
    c = set_field(c, AW + 6, 2, 3);
    apply(c, 8'h01, 1'b0);
    chk("R6 mode 3 is zero", {7'b0, fout}, 8'h0);
  endtask

  task automatic t_fold;
    logic [CW-1:0] c = '0;
    c[4*PW + 2*7] = 1'b1;
    c = set_field(c, AW + 11, 3, 4);
    apply(c, 8'h80, 1'b0);
    chk("R7 fold low", {7'b0, fold}, 8'h0);
    apply(c, 8'h00, 1'b0);
    chk("R7 fold high", {7'b0, fold}, 8'h1);
    c = set_field(c, AW + 11, 3, 7);
    apply(c, 8'h80, 1'b0);
    chk("R7 fold out of range", {7'b0, fold}, 8'h1);
  endtask

  task automatic t_chain;
    for (int k = 0; k < 8; k++) begin
      logic [CW-1:0] c = '0;
      for (int t = 0; t < 5; t++) begin
        int v = k * 5 + t + 1;
        for (int j = 0; j < N; j++) c[t*PW + 2*j + (((v >> j) & 1) ? 0 : 1)] = 1'b1;
      end
      c = set_field(c, AW, 5, 5'h1F);
      c[AW + 5] = (k != 0);
      ccfg[k] = c;
    end
    for (int v = 0; v < 64; v++) begin
      apply('0, 8'(v), 1'b0);
      chk("R8 chain sum", {7'b0, chn[8]}, {7'b0, (v >= 1 && v <= 40)});
    end
    chk("R8 chain out", {7'b0, cfo[7]}, {7'b0, chn[8]});
  endtask

  task automatic t_random;
    for (int n = 0; n < 300; n++) begin
      logic [CW-1:0] c = '0;
      logic [N-1:0] b = 8'($urandom);
      logic ci = 1'($urandom);
      logic [4:0] p, ec;
      logic s, xi;
      int xs, fs, xm;
      for (int q = 0; q < 5 * N; q++) begin
        int r = int'($urandom_range(0, 19));
        c[2*q +: 2] = (r < 15) ? 2'b00 : (r < 17) ? 2'b01 : (r < 19) ? 2'b10 : 2'b11;
      end
      c[AW +: 14] = 14'($urandom);
      for (int i = 0; i < 5; i++) p[i] = mterm(c, i, b);
      ec = p & ~c[AW +: 5];
      s = (|(p & c[AW +: 5])) | (c[AW + 5] & ci);
      xm = int'(c[AW + 6 +: 2]);
      xs = int'(c[AW + 8 +: 3]);
      fs = int'(c[AW + 11 +: 3]);
      xi = (xm == 1) ? 1'b1 : (xm == 2 && xs < 5) ? p[xs] : 1'b0;
      apply(c, b, ci);
      chk("R1 R4 random side", {3'b0, ctrl}, {3'b0, ec});
      chk("R5 random sum", {7'b0, cout}, {7'b0, s});
      chk("R6 random out", {7'b0, fout}, {7'b0, s ^ xi});
      chk("R7 random fold", {7'b0, fold}, {7'b0, (fs < 5) ? ~p[fs] : 1'b1});
    end
  endtask

  initial begin
    cfg = '0; bus = '0; cin = 1'b0;
    for (int k = 0; k < 8; k++) ccfg[k] = '0;
    repeat (2) @(posedge clk);
    t_reset;
    t_literals;
    t_empty;
    t_conflict;
    t_steer;
    t_cascade;
    t_xor;
    t_fold;
    t_chain;
    t_random;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule